// File: doc/BRIEF.md
# Auto-Restart Supervisor with Eight-Cycle Skip Counter

This block sequences start-up, fault recovery and thermal shutdown for a switching power controller. It watches four comparator flags: supply has reached the upper threshold, supply has sagged to the lower threshold, supply is under the power-up reset level, and die temperature is over the shutdown limit. From these it drives two controls. One is the enable for the start-up charge source that feeds the supply capacitor. The other is the switching enable for the PWM stage.

After power-up the block charges the supply until the upper threshold is first reached, and then hands over to normal switching. When regulation is lost, the supply sags to the lower threshold. The block then stops switching and regulates the supply between the two thresholds by turning the charge source on and off. It lets switching resume only on the eighth charge-up, so a persistent fault gives a low auto-restart duty cycle.

A drop below the power-up reset level restarts the whole sequence. Over-temperature holds switching off until the temperature flag is released. The raw flags are asynchronous to the clock and are synchronized inside the block. The threshold flags act only on their rising edges.

Top module: `arsup_top`

## Requirements
- R1: After reset the charge source is on (`chg_en`=1), switching is off (`sw_en`=0), `st_mode` is 0 (start-up) and `st_count` is 0.
- R2: In start-up with no over-temperature, a rising edge of `sup_above_hi` moves the block to run mode (`st_mode`=1), with `sw_en`=1 and `chg_en`=0.
- R3: In run mode the charge source stays off, and edges of `sup_above_hi` have no effect. A rising edge of `sup_below_lo` enters auto-restart (`st_mode`=2) with `sw_en`=0, `chg_en`=1 and `st_count`=0.
- R4: In auto-restart and in thermal hold, a rising edge of `sup_below_lo` turns the charge source on and a rising edge of `sup_above_hi` turns it off.
- R5: In auto-restart each rising edge of `sup_above_hi` raises `st_count` by one. Edges of `sup_below_lo` leave the count unchanged.
- R6: A rising edge of `sup_above_hi` in auto-restart with `st_count`=7 wraps the count to 0 and enters run mode. Run mode is therefore reached on the eighth charge-up after the fault.
- R7: `sw_en` is 1 only in run mode and is never 1 while `chg_en` is 1.
- R8: While `sup_below_por` is high the block is held in start-up with `st_count`=0 and the charge source on, whatever the other flags do. After release, one upper-threshold edge is enough to start switching.
- R9: With `temp_hot` high, run mode and auto-restart go to thermal hold (`st_mode`=3, `sw_en`=0). In start-up, `temp_hot` high blocks the move to run mode.
- R10: Releasing `temp_hot` in thermal hold enters run mode with `st_count`=0 and `chg_en`=0.
- R11: A change on a raw input flag reaches the outputs on the third rising clock edge after it is applied (two synchronizer stages plus the state register), and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_above_hi | input | 1 | Raw flag: supply at or above upper threshold |
| sup_below_lo | input | 1 | Raw flag: supply at or below lower threshold |
| sup_below_por | input | 1 | Raw flag: supply under power-up reset level |
| temp_hot | input | 1 | Raw flag: over-temperature (sensor applies the hysteresis) |
| chg_en | output | 1 | Start-up charge source enable |
| sw_en | output | 1 | PWM switching enable |
| st_mode | output | 2 | State: 0 start-up, 1 run, 2 auto-restart, 3 thermal hold |
| st_count | output | CNT_W | Auto-restart cycle count |

## Verification
Every output is registered behind a two-stage synchronizer. A raw flag applied just after a falling clock edge therefore shows on the outputs after the third rising edge. The bench drives inputs on falling edges and samples three falling edges later. For R11 it also samples after two edges, to confirm that nothing has moved yet. Falling edges of the threshold flags have no effect, so each pulse is cleared and allowed to settle before the next stimulus.

// File: rtl/arsup_pkg.sv
package arsup_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_FAULT = 2'd2,
    ST_HOT   = 2'd3
  } arsup_state_e;
endpackage

// File: rtl/arsup_sync.sv
module arsup_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/arsup_edge.sv
module arsup_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= '0;
    else        prev <= lvl;

  assign rise = lvl & ~prev;
endmodule

// File: rtl/arsup_seq.sv
module arsup_seq
  import arsup_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por,
  input  logic             hot,
  input  logic             hi_rise,
  input  logic             lo_rise,
  output arsup_state_e     state,
  output logic [CNT_W-1:0] count,
  output logic             chg,
  output logic             sw
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_START;
      count <= '0;
      chg   <= 1'b1;
    end else if (por) begin
      state <= ST_START;
      count <= '0;
      chg   <= 1'b1;
    end else begin
      unique case (state)
        ST_START: if (hi_rise && !hot) begin
          state <= ST_RUN;
          chg   <= 1'b0;
        end
        ST_RUN: begin
          if (hot) state <= ST_HOT;
          else if (lo_rise) begin
            state <= ST_FAULT;
            count <= '0;
            chg   <= 1'b1;
          end
        end
        ST_FAULT: begin
          if (hot) state <= ST_HOT;
          else if (hi_rise) begin
            chg <= 1'b0;
            if (count == CNT_LAST) begin
              state <= ST_RUN;
              count <= '0;
            end else begin
              count <= count + 1'b1;
            end
          end else if (lo_rise) chg <= 1'b1;
        end
        ST_HOT: begin
          if (!hot) begin
            state <= ST_RUN;
            count <= '0;
            chg   <= 1'b0;
          end else if (hi_rise) chg <= 1'b0;
          else if (lo_rise)     chg <= 1'b1;
        end
        default: state <= ST_START;
      endcase
    end
  end

  assign sw = (state == ST_RUN);
endmodule

// File: rtl/arsup_top.sv
module arsup_top
  import arsup_pkg::*;
#(
  parameter int CNT_W     = 3,
  parameter int SYNC_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_above_hi,
  input  logic             sup_below_lo,
  input  logic             sup_below_por,
  input  logic             temp_hot,
  output logic             chg_en,
  output logic             sw_en,
  output logic [1:0]       st_mode,
  output logic [CNT_W-1:0] st_count
);
  logic [3:0]   raw_flags, sync_flags;
  logic [1:0]   rises;
  logic         hi_s, lo_s, por_s, hot_s;
  arsup_state_e state;

  assign raw_flags = {sup_below_por, temp_hot, sup_below_lo, sup_above_hi};

  arsup_sync #(.W(4), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_flags), .q(sync_flags)
  );

  assign {por_s, hot_s, lo_s, hi_s} = sync_flags;

  arsup_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl({lo_s, hi_s}), .rise(rises)
  );

  arsup_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .por(por_s), .hot(hot_s),
    .hi_rise(rises[0]), .lo_rise(rises[1]),
    .state(state), .count(st_count), .chg(chg_en), .sw(sw_en)
  );

  assign st_mode = state;
endmodule

// File: rtl/arsup_chk.sv
module arsup_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_s,
  input logic             hot_s,
  input logic             chg_en,
  input logic             sw_en,
  input logic [1:0]       st_mode,
  input logic [CNT_W-1:0] st_count
);
  localparam logic [CNT_W-1:0] LAST = '1;

  // R7
  sw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> !chg_en);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mode == 2'd2 && !por_s) |=>
      (st_mode != 2'd2) || (st_count == $past(st_count)) ||
      (st_count == $past(st_count) + 1'b1));

  // R6
  wrap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_mode == 2'd2 && !por_s && !hot_s) |=>
      (st_mode != 2'd1) || ($past(st_count) == LAST));

  // R8
  por_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_s |=> (st_mode == 2'd0 && st_count == '0 && chg_en));

  // R9
  hot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_s && !por_s && st_mode == 2'd1) |=> (st_mode == 2'd3 && !sw_en));
endmodule

bind arsup_top arsup_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .por_s(por_s), .hot_s(hot_s),
  .chg_en(chg_en), .sw_en(sw_en), .st_mode(st_mode), .st_count(st_count)
);

// File: tb/arsup_top_bench.sv
module arsup_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hi = 1'b0, lo = 1'b0, por = 1'b0, hot = 1'b0;
  logic       chg_en, sw_en;
  logic [1:0] st_mode;
  logic [2:0] st_count;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  arsup_top u_arsup_top (
    .clk(clk), .rst_n(rst_n), .sup_above_hi(hi), .sup_below_lo(lo),
    .sup_below_por(por), .temp_hot(hot), .chg_en(chg_en), .sw_en(sw_en),
    .st_mode(st_mode), .st_count(st_count)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_out(input string req, input int m, input int c,
                         input int ch, input int sw);
    chk({req, " mode"}, st_mode, m);
    chk({req, " count"}, st_count, c);
    chk({req, " chg_en"}, chg_en, ch);
    chk({req, " sw_en"}, sw_en, sw);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hi = 0; lo = 0; por = 0; hot = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic pulse_hi();
    hi = 1'b1; step(3); hi = 1'b0; step(3);
  endtask

  task automatic pulse_lo();
    lo = 1'b1; step(3); lo = 1'b0; step(3);
  endtask

  task automatic t_reset();
    do_reset();
    chk_out("R1", 0, 0, 1, 0);
  endtask

  task automatic t_startup();
    do_reset();
    hi = 1'b1;
    step(2);
    chk("R11 early", sw_en, 0);
    step(1);
    chk_out("R2", 1, 0, 0, 1);
    hi = 1'b0; step(3);
    pulse_hi();
    chk_out("R3 hi ignored in run", 1, 0, 0, 1);
  endtask

  task automatic t_restart();
    do_reset();
    pulse_hi();
    pulse_lo();
    chk_out("R3", 2, 0, 1, 0);
    for (int k = 1; k < 8; k++) begin
      pulse_hi();
      chk_out("R5", 2, k, 0, 0);
      pulse_lo();
      chk_out("R4", 2, k, 1, 0);
    end
    pulse_hi();
    chk_out("R6", 1, 0, 0, 1);
  endtask

  task automatic t_por();
    do_reset();
    pulse_hi();
    pulse_lo();
    pulse_hi(); pulse_lo(); pulse_hi();
    chk("R5 partial", st_count, 2);
    por = 1'b1; step(3);
    chk_out("R8 hold", 0, 0, 1, 0);
    pulse_hi();
    chk_out("R8 blocked", 0, 0, 1, 0);
    por = 1'b0; step(3);
    pulse_hi();
    chk_out("R8 restart", 1, 0, 0, 1);
  endtask

  task automatic t_hot();
    do_reset();
    pulse_hi();
    hot = 1'b1; step(3);
    chk_out("R9 run", 3, 0, 0, 0);
    pulse_lo();
    chk("R4 hot lo", chg_en, 1);
    pulse_hi();
    chk("R4 hot hi", chg_en, 0);
    hot = 1'b0; step(3);
    chk_out("R10", 1, 0, 0, 1);
    pulse_lo(); pulse_hi();
    hot = 1'b1; step(3);
    chk_out("R9 fault", 3, 1, 0, 0);
    hot = 1'b0; step(3);
    chk_out("R10 from fault", 1, 0, 0, 1);
  endtask

  task automatic t_hot_start();
    do_reset();
    hot = 1'b1; step(3);
    pulse_hi();
    chk_out("R9 start", 0, 0, 1, 0);
    hot = 1'b0; step(3);
    chk_out("R9 start release", 0, 0, 1, 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_restart();
    t_por();
    t_hot();
    t_hot_start();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule